// File: doc/BRIEF.md
# Two-Channel System Timer

This peripheral holds two counting channels that share one input clock and sit behind a plain 32-bit register read/write port. Channel 1 is a one-shot event timer. Software loads a compare value, clears the counter and enables the channel. The counter then climbs until it equals the compare value, latches a match flag and stops there. The flag drives an interrupt line through a mask bit. Channel 2 is a timebase that runs freely and wraps. Software reads its low word, and the upper word is captured at that moment into a buffer, so the two halves always form one consistent value.

Each channel has its own 2-bit prescaler field in a shared control register. The field selects a divide ratio that is a power of four. Enables are changed through separate write-one-to-set and write-one-to-clear registers, so one channel can be touched without a read-modify-write of the other. Each counter can be zeroed through its own bit in a clear register. Register offsets (byte addresses): control 0x00, counter clear 0x08, flag 0x0C, mask 0x10, channel-1 compare 0x14, channel-1 count 0x18, timebase low 0x20, timebase high buffer 0x24, enable-set 0x34, enable-clear 0x38.

Top module: `twin_timer`

## Requirements
- R1: After reset the control register reads 0, the flag reads 0, the mask reads 1, the enable state at 0x34 reads 0 and both counters read 0. Control (bits [3:0]) and compare read back what was written.
- R2: Control bits [1:0] select the channel-1 divide ratio and bits [3:2] select the channel-2 divide ratio. Field values 0, 1 and 2 divide by 1, 4 and 16, and value 3 divides by 16. The divider restarts from zero whenever its channel is disabled, so a channel enabled for D cycles advances floor(D / ratio) times.
- R3: Writing 1 to bit 0 or bit 1 at 0x34 enables channel 1 or channel 2. Writing 1 to the same bit at 0x38 disables that channel. Zero bits in either register leave the enable state unchanged. Reading 0x34 returns the enable state in bits [1:0].
- R4: Writing 1 to bit 0 at 0x08 zeroes the channel-1 counter, and writing 1 to bit 1 zeroes the whole channel-2 counter. Zero bits have no effect.
- R5: While enabled, the channel-1 counter advances once per divider tick until it equals the compare value. On that step, flag bit 0 sets and the counter then holds its value until it is cleared.
- R6: Writing 0 to flag bit 0 clears the flag, and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: irq_o is high exactly when the flag is set and mask bit 0 is clear. It follows writes to the flag and mask in the same clock edge.
- R8: The channel-2 counter is TB_LO_W+TB_HI_W bits wide. It advances once per divider tick while enabled, wraps to zero after its maximum value, and stays unchanged while disabled.
- R9: A read of 0x20 returns the low TB_LO_W bits and, in the same cycle, copies the upper TB_HI_W bits into the buffer that 0x24 returns. The buffer changes on no other event.
- R10: Read data appears on rdata_o one clock after the read request and holds until the next read. Unmapped offsets, the clear register and the enable-clear register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared timer and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Channel-1 interrupt, flag and not mask |

## Verification
The bench builds the block with an 8-bit low word and a 4-bit high word for the timebase, and leaves the other widths at their defaults. With these sizes, a carry into the high word happens within a few hundred cycles and a full wrap within about four thousand. That makes the snapshot buffer, the carry across the word boundary and the wrap to zero reachable with exact expected values. Divider ratios are measured by running a channel for a known number of cycles between an enable write and a disable write. The one-shot channel is checked with a flag-clear write placed on the exact cycle of the match.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int ADDR_W = 6;
  localparam int NCH    = 2;
  localparam int SEL_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] A_CLR  = 6'h08;
  localparam logic [ADDR_W-1:0] A_FLAG = 6'h0C;
  localparam logic [ADDR_W-1:0] A_MASK = 6'h10;
  localparam logic [ADDR_W-1:0] A_CMP  = 6'h14;
  localparam logic [ADDR_W-1:0] A_CNT1 = 6'h18;
  localparam logic [ADDR_W-1:0] A_TBLO = 6'h20;
  localparam logic [ADDR_W-1:0] A_TBHI = 6'h24;
  localparam logic [ADDR_W-1:0] A_ENS  = 6'h34;
  localparam logic [ADDR_W-1:0] A_ENC  = 6'h38;
endpackage

// File: rtl/twin_timer_presc.sv
module twin_timer_presc #(
  parameter int SEL_W   = 2,
  parameter int MAX_SEL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 2 * MAX_SEL;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  // ratio is 4**sel, capped at 4**MAX_SEL
  always_comb begin
    if (sel_i >= SEL_W'(MAX_SEL)) lim = '1;
    else lim = DIV_W'((32'd1 << (32'd2 * 32'(sel_i))) - 32'd1);
  end

  assign tick_o = run_i && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/twin_timer_evt.sv
module twin_timer_evt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] inc;
  logic         at_cmp;

  assign inc     = cnt_q + 1'b1;
  assign at_cmp  = (cnt_q == cmp_i);
  assign match_o = tick_i && !clr_i && !at_cmp && (inc == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i && !at_cmp)  cnt_q <= inc;
  end
endmodule

// File: rtl/twin_timer_tb.sv
module twin_timer_tb #(
  parameter int LO_W = 32,
  parameter int HI_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 clr_i,
  output logic [LO_W+HI_W-1:0] cnt_o
);
  localparam int W = LO_W + HI_W;

  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CMP_W   = 32,
  parameter int TB_LO_W = 32,
  parameter int TB_HI_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int TB_W   = TB_LO_W + TB_HI_W;
  localparam int CTRL_W = NCH * SEL_W;

  logic              wr, rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]    en_q, en_set, en_clr, cnt_clr, tick;
  logic              flag_q, mask_q, match;
  logic [CMP_W-1:0]  cmp_q, cnt1;
  logic [TB_W-1:0]   tb_cnt;
  logic [TB_HI_W-1:0] hi_buf_q;
  logic [DATA_W-1:0] rdata_q, rd_nxt;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  assign en_set  = (wr && addr_i == A_ENS) ? wdata_i[NCH-1:0] : '0;
  assign en_clr  = (wr && addr_i == A_ENC) ? wdata_i[NCH-1:0] : '0;
  assign cnt_clr = (wr && addr_i == A_CLR) ? wdata_i[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_presc
    twin_timer_presc #(.SEL_W(SEL_W), .MAX_SEL(2)) presc_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (en_q[g]),
      .sel_i  (ctrl_q[g*SEL_W +: SEL_W]),
      .tick_o (tick[g])
    );
  end

  twin_timer_evt #(.W(CMP_W)) evt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick[0]),
    .clr_i   (cnt_clr[0]),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt1),
    .match_o (match)
  );

  twin_timer_tb #(.LO_W(TB_LO_W), .HI_W(TB_HI_W)) tb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick[1]),
    .clr_i  (cnt_clr[1]),
    .cnt_o  (tb_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      en_q     <= '0;
      flag_q   <= 1'b0;
      mask_q   <= 1'b1;
      cmp_q    <= '0;
      hi_buf_q <= '0;
    end else begin
      en_q <= (en_q | en_set) & ~en_clr;
      if (wr && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr && addr_i == A_MASK) mask_q <= wdata_i[0];
      if (wr && addr_i == A_CMP)  cmp_q  <= wdata_i[CMP_W-1:0];
      // match beats a clearing write
      if (match)                                          flag_q <= 1'b1;
      else if (wr && addr_i == A_FLAG && !wdata_i[0])     flag_q <= 1'b0;
      if (rd && addr_i == A_TBLO) hi_buf_q <= tb_cnt[TB_W-1:TB_LO_W];
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (addr_i)
      A_CTRL: rd_nxt[CTRL_W-1:0]  = ctrl_q;
      A_FLAG: rd_nxt[0]           = flag_q;
      A_MASK: rd_nxt[0]           = mask_q;
      A_CMP:  rd_nxt[CMP_W-1:0]   = cmp_q;
      A_CNT1: rd_nxt[CMP_W-1:0]   = cnt1;
      A_TBLO: rd_nxt[TB_LO_W-1:0] = tb_cnt[TB_LO_W-1:0];
      A_TBHI: rd_nxt[TB_HI_W-1:0] = hi_buf_q;
      A_ENS:  rd_nxt[NCH-1:0]     = en_q;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flag_q && !mask_q;
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMP_W  = 32,
  parameter int TB_W   = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [NCH-1:0]    en_q,
  input logic [CMP_W-1:0]  cnt1,
  input logic [CMP_W-1:0]  cmp_q,
  input logic              flag_q,
  input logic [TB_W-1:0]   tb_cnt
);
  logic wr_ens, wr_enc, wr_clr, wr_mask, wr_cmp;
  assign wr_ens  = req_i && we_i && addr_i == A_ENS;
  assign wr_enc  = req_i && we_i && addr_i == A_ENC;
  assign wr_clr  = req_i && we_i && addr_i == A_CLR;
  assign wr_mask = req_i && we_i && addr_i == A_MASK;
  assign wr_cmp  = req_i && we_i && addr_i == A_CMP;

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ens && wdata_i[0] |=> en_q[0]); // R3
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_enc && wdata_i[0] |=> !en_q[0]); // R3
  AST_CLR_CH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr && wdata_i[0] |=> cnt1 == '0); // R4
  AST_CH1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt1 == cmp_q) && !(wr_clr && wdata_i[0]) && !wr_cmp |=> $stable(cnt1)); // R5
  AST_FLAG_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt1 == cmp_q) && (cmp_q != '0) && !$stable(cnt1) && $stable(cmp_q) |-> flag_q); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask && wdata_i[0] |=> !irq_o); // R7
  AST_TB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[1] && !(wr_clr && wdata_i[1]) |=> $stable(tb_cnt)); // R8
endmodule

bind twin_timer twin_timer_chk #(
  .DATA_W (DATA_W),
  .CMP_W  (CMP_W),
  .TB_W   (TB_LO_W + TB_HI_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .cnt1    (cnt1),
  .cmp_q   (cmp_q),
  .flag_q  (flag_q),
  .tb_cnt  (tb_cnt)
);

// File: tb/twin_timer_tb_top.sv
module twin_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [5:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_timer #(.DATA_W(32), .CMP_W(32), .TB_LO_W(8), .TB_HI_W(4)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // channel-2 runs for n+2 cycles between enable and disable
  task automatic run_tb(input logic [3:0] ctrl, input int n, input int exp, input string tag);
    logic [DW-1:0] v;
    wr(6'h00, {28'd0, ctrl});
    wr(6'h08, 32'h2);
    wr(6'h34, 32'h2);
    idle(n);
    wr(6'h38, 32'h2);
    rd(6'h20, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(6'h00, v); check("R1 ctrl reset", v, 0);
    rd(6'h0C, v); check("R1 flag reset", v, 0);
    rd(6'h10, v); check("R1 mask reset", v, 1);
    rd(6'h34, v); check("R1 enable reset", v, 0);
    rd(6'h18, v); check("R1 cnt1 reset", v, 0);
    rd(6'h20, v); check("R1 tb reset", v, 0);
    check("R7 irq reset", {31'd0, irq}, 0);
  endtask

  task automatic t_regs;
    logic [DW-1:0] v;
    wr(6'h00, 32'h9);      rd(6'h00, v); check("R1 ctrl rb", v, 32'h9);
    wr(6'h14, 32'h1234);   rd(6'h14, v); check("R1 cmp rb", v, 32'h1234);
    rd(6'h04, v); check("R10 unmapped", v, 0);
    rd(6'h38, v); check("R10 enclr reads 0", v, 0);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_presc;
    run_tb(4'h0, 8,  10, "R2 div1");
    run_tb(4'h4, 16, 4,  "R2 div4 18cyc");
    run_tb(4'h4, 13, 3,  "R2 div4 15cyc");
    run_tb(4'h8, 62, 4,  "R2 div16 64cyc");
    run_tb(4'hC, 62, 4,  "R2 sel3 64cyc");
    run_tb(4'hC, 60, 3,  "R2 sel3 62cyc");
  endtask

  task automatic t_enable;
    logic [DW-1:0] v;
    wr(6'h14, 32'hFFFF_FFFF);
    run_tb(4'h0, 3, 5, "R3 tb baseline");
    wr(6'h34, 32'h1);
    idle(5);
    rd(6'h20, v); check("R3 ch1 set leaves ch2", v, 5);
    rd(6'h34, v); check("R3 en state", v, 1);
    wr(6'h38, 32'h2);
    rd(6'h34, v); check("R3 clr other bit", v, 1);
    wr(6'h34, 32'h0);
    rd(6'h34, v); check("R3 set zero", v, 1);
    wr(6'h38, 32'h1);
    rd(6'h34, v); check("R3 ch1 stopped", v, 0);
  endtask

  task automatic t_clear;
    logic [DW-1:0] v;
    wr(6'h08, 32'h0);
    rd(6'h20, v); check("R4 clr zero ignored", v, 5);
    wr(6'h08, 32'h1);
    rd(6'h20, v); check("R4 clr ch1 keeps ch2", v, 5);
    rd(6'h18, v); check("R4 ch1 zeroed", v, 0);
    wr(6'h08, 32'h2);
    rd(6'h20, v); check("R4 ch2 zeroed", v, 0);
  endtask

  task automatic t_oneshot;
    logic [DW-1:0] v;
    wr(6'h00, 32'h0);
    wr(6'h14, 32'd5);
    wr(6'h34, 32'h1);
    idle(20);
    rd(6'h18, v); check("R5 cnt1 held", v, 5);
    rd(6'h0C, v); check("R5 flag set", v, 1);
    check("R7 masked irq", {31'd0, irq}, 0);
    wr(6'h10, 32'h0);
    check("R7 unmasked irq", {31'd0, irq}, 1);
  endtask

  task automatic t_flag;
    logic [DW-1:0] v;
    wr(6'h0C, 32'h1);
    rd(6'h0C, v); check("R6 write1 keeps", v, 1);
    wr(6'h0C, 32'h0);
    check("R7 irq after clear", {31'd0, irq}, 0);
    idle(10);
    rd(6'h0C, v); check("R6 no retrigger when held", v, 0);
    wr(6'h08, 32'h1);
    idle(10);
    rd(6'h0C, v); check("R5 rearm via clear", v, 1);
    check("R7 irq rearm", {31'd0, irq}, 1);
    // collision: match lands on the flag-clear edge
    wr(6'h38, 32'h1);
    wr(6'h08, 32'h1);
    wr(6'h14, 32'd8);
    wr(6'h0C, 32'h0);
    wr(6'h34, 32'h1);
    idle(6);
    wr(6'h0C, 32'h0);
    rd(6'h0C, v); check("R6 match wins", v, 1);
    wr(6'h0C, 32'h0);
    rd(6'h0C, v); check("R6 clear", v, 0);
    wr(6'h38, 32'h1);
    wr(6'h10, 32'h1);
  endtask

  task automatic t_snap;
    logic [DW-1:0] v;
    run_tb(4'h0, 300, 46, "R8 low after carry");
    rd(6'h24, v); check("R9 hi captured", v, 1);
    wr(6'h34, 32'h2);
    idle(300);
    wr(6'h38, 32'h2);
    rd(6'h24, v); check("R9 buffer holds", v, 1);
    rd(6'h20, v); check("R8 low 604", v, 92);
    rd(6'h24, v); check("R9 hi refreshed", v, 2);
  endtask

  task automatic t_wrap;
    logic [DW-1:0] v;
    run_tb(4'h0, 4097, 3, "R8 wrap low");
    rd(6'h24, v); check("R8 wrap high", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL WATCHDOG run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regs;
    t_presc;
    t_enable;
    t_clear;
    t_oneshot;
    t_flag;
    t_snap;
    t_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule